// File: doc/BRIEF.md
# NVM Shadow Copy Controller

This block sits between a small byte-wide register bus and two memories: a non-volatile program array and the shadow RAM that the processor core executes from. Software sets one command bit to reload the whole shadow RAM from the non-volatile array, and another to commit the whole shadow RAM back into the array. While a reload runs, the block holds the core in reset. When the reload is done it releases the core, which then fetches from address zero.

Single bytes can also be programmed. Software loads a 16-bit target address through two byte registers. Writing the data register then launches the program. Every word write to the array is guarded by a cycle-count limit. A write that gets no completion handshake within that limit is abandoned and raises a sticky failure flag. A separate byte-done flag reports single-byte completions only, and it clears when the control register is read.

Top module: `nvm_shadow_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, core_rst is low and neither memory request is active.
- R2: Writing the control register (offset 0) with bit 7 set while idle copies array words 0 to DEPTH-1 into shadow RAM at the same index. If bits 7 and 6 are both set, only the reload runs. Shadow writes stay below DEPTH.
- R3: core_rst rises in the cycle after the reload command and falls when the last shadow word is written. The shadow RAM is written only while core_rst is high, and the array is never written while it is high.
- R4: Control bit 7 reads 1 while the reload runs and clears itself on completion.
- R5: Writing the control register with bit 6 set (bit 7 clear) while idle copies shadow words 0 to DEPTH-1 into the array at the same index. Bit 6 reads 1 during the copy and clears itself at the end.
- R6: A write to the data register (offset 3) while idle programs that byte at address {high register (offset 2), low register (offset 1)}. On completion, control bit 5 is set.
- R7: A read of the control register clears bit 5. Bulk copies never set bit 5.
- R8: If nvm_done has not arrived after TIMEOUT_CYC cycles of nvm_wr_req, the request drops after exactly TIMEOUT_CYC cycles. Control bit 4 is then set and the array word keeps its old value. A timed-out byte program still sets bit 5.
- R9: Control bit 4 is cleared in the cycle that a new bulk copy or byte program starts.
- R10: While any operation is busy, writes to all four registers are ignored. This covers command bits, the address registers and the data register.
- R11: Control bits 3 to 0 always read 0.
- R12: nvm_rd_req and nvm_wr_req are never high together. nvm_addr and nvm_wdata hold steady while nvm_wr_req stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears byte-done on control reads) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| nvm_rd_req | output | 1 | Array read request, held until nvm_done |
| nvm_wr_req | output | 1 | Array write request, held until nvm_done or timeout |
| nvm_addr | output | 16 | Array word address |
| nvm_wdata | output | 8 | Array write data |
| nvm_rdata | input | 8 | Array read data, valid with nvm_done |
| nvm_done | input | 1 | Array step completion pulse |
| ram_wr | output | 1 | Shadow RAM write enable |
| ram_addr | output | IDX_W | Shadow RAM address |
| ram_wdata | output | 8 | Shadow RAM write data |
| ram_rdata | input | 8 | Shadow RAM read data, one cycle after address |
| core_rst | output | 1 | Core reset held during reload |

## Verification
The reload is tested with an array pattern that differs at every index. Any skipped, repeated or shifted word therefore shows up in the shadow compare. The commit uses a separate inverted pattern, so its result cannot be confused with the reload's. Byte programs are driven from a vector table whose addresses span both high-register values, the lowest and highest low-register values, and data of all-ones and all-zeros. This separates correct concatenation and data paths from swapped or truncated ones. A stalled array is then used to tell a clean timeout apart from a completed write. A follow-up program shows that the failure flag is cleared at the start of the next operation.

// File: rtl/nvm_shadow_pkg.sv
package nvm_shadow_pkg;
    localparam int REG_W  = 8;
    localparam int NVM_AW = 2 * REG_W;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_ALO  = 2'd1;
    localparam logic [1:0] OFS_AHI  = 2'd2;
    localparam logic [1:0] OFS_DATA = 2'd3;

    localparam int BIT_RELOAD = 7;
    localparam int BIT_COMMIT = 6;
    localparam int BIT_BDONE  = 5;
    localparam int BIT_FAIL   = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD_RD,
        SQ_LOAD_WR,
        SQ_CMT_ADDR,
        SQ_CMT_CAP,
        SQ_CMT_WR,
        SQ_BYTE_WR
    } seq_state_e;
endpackage

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int LIMIT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        expired = run && (tmr_q.cnt == CNT_W'(LIMIT - 1));
        if (!run) begin
            tmr_d.cnt = '0;
        end else if (!expired) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_shadow_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_load,
    input  logic              start_commit,
    input  logic              start_byte,
    input  logic [NVM_AW-1:0] byte_addr,
    input  logic [REG_W-1:0]  byte_data,
    output logic              nvm_rd_req,
    output logic              nvm_wr_req,
    output logic [NVM_AW-1:0] nvm_addr,
    output logic [REG_W-1:0]  nvm_wdata,
    input  logic [REG_W-1:0]  nvm_rdata,
    input  logic              nvm_done,
    output logic              ram_wr,
    output logic [IDX_W-1:0]  ram_addr,
    output logic [REG_W-1:0]  ram_wdata,
    input  logic [REG_W-1:0]  ram_rdata,
    input  logic              tmo_expired,
    output logic              tmo_run,
    output logic              busy,
    output logic              load_active,
    output logic              commit_active,
    output logic              byte_done,
    output logic              wr_fail
);
    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] buf_w;
    } seq_t;

    seq_t s_d, s_q;
    logic last_idx;

    assign last_idx = (s_q.idx == IDX_W'(DEPTH - 1));

    always_comb begin
        s_d        = s_q;
        nvm_rd_req = 1'b0;
        nvm_wr_req = 1'b0;
        nvm_addr   = NVM_AW'(s_q.idx);
        nvm_wdata  = s_q.buf_w;
        ram_wr     = 1'b0;
        ram_addr   = s_q.idx;
        ram_wdata  = s_q.buf_w;
        tmo_run    = 1'b0;
        byte_done  = 1'b0;
        wr_fail    = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start_load) begin
                    s_d.st  = SQ_LOAD_RD;
                    s_d.idx = '0;
                end else if (start_commit) begin
                    s_d.st  = SQ_CMT_ADDR;
                    s_d.idx = '0;
                end else if (start_byte) begin
                    s_d.st  = SQ_BYTE_WR;
                end
            end
            SQ_LOAD_RD: begin
                nvm_rd_req = 1'b1;
                if (nvm_done) begin
                    s_d.buf_w = nvm_rdata;
                    s_d.st    = SQ_LOAD_WR;
                end
            end
            SQ_LOAD_WR: begin
                ram_wr = 1'b1;
                if (last_idx) begin
                    s_d.st = SQ_IDLE;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.st  = SQ_LOAD_RD;
                end
            end
            SQ_CMT_ADDR: begin
                s_d.st = SQ_CMT_CAP;
            end
            SQ_CMT_CAP: begin
                s_d.buf_w = ram_rdata;
                s_d.st    = SQ_CMT_WR;
            end
            SQ_CMT_WR: begin
                nvm_wr_req = 1'b1;
                tmo_run    = 1'b1;
                if (nvm_done || tmo_expired) begin
                    wr_fail = !nvm_done;
                    if (last_idx) begin
                        s_d.st = SQ_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = SQ_CMT_ADDR;
                    end
                end
            end
            SQ_BYTE_WR: begin
                nvm_wr_req = 1'b1;
                nvm_addr   = byte_addr;
                nvm_wdata  = byte_data;
                tmo_run    = 1'b1;
                if (nvm_done || tmo_expired) begin
                    wr_fail   = !nvm_done;
                    byte_done = 1'b1;
                    s_d.st    = SQ_IDLE;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    assign busy          = (s_q.st != SQ_IDLE);
    assign load_active   = (s_q.st == SQ_LOAD_RD) || (s_q.st == SQ_LOAD_WR);
    assign commit_active = (s_q.st == SQ_CMT_ADDR) || (s_q.st == SQ_CMT_CAP)
                         || (s_q.st == SQ_CMT_WR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, idx: '0, buf_w: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/nvm_csr.sv
module nvm_csr
    import nvm_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              load_active,
    input  logic              commit_active,
    input  logic              byte_done,
    input  logic              wr_fail,
    output logic              start_load,
    output logic              start_commit,
    output logic              start_byte,
    output logic [NVM_AW-1:0] byte_addr,
    output logic [REG_W-1:0]  byte_data
);
    typedef struct packed {
        logic [REG_W-1:0] alo;
        logic [REG_W-1:0] ahi;
        logic [REG_W-1:0] dat;
        logic             bdone;
        logic             fail;
    } csr_t;

    csr_t c_d, c_q;
    logic wr_ok;
    logic ctrl_rd;

    always_comb begin
        c_d          = c_q;
        wr_ok        = reg_wr && !busy;
        ctrl_rd      = reg_rd && (reg_addr == OFS_CTRL);
        start_load   = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[BIT_RELOAD];
        start_commit = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[BIT_COMMIT]
                     && !reg_wdata[BIT_RELOAD];
        start_byte   = wr_ok && (reg_addr == OFS_DATA);

        if (wr_ok && reg_addr == OFS_ALO)  c_d.alo = reg_wdata;
        if (wr_ok && reg_addr == OFS_AHI)  c_d.ahi = reg_wdata;
        if (start_byte)                    c_d.dat = reg_wdata;

        if (start_load || start_commit || start_byte) c_d.fail = 1'b0;
        if (wr_fail)                                  c_d.fail = 1'b1;

        if (ctrl_rd)   c_d.bdone = 1'b0;
        if (byte_done) c_d.bdone = 1'b1;

        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata             = '0;
                reg_rdata[BIT_RELOAD] = load_active;
                reg_rdata[BIT_COMMIT] = commit_active;
                reg_rdata[BIT_BDONE]  = c_q.bdone;
                reg_rdata[BIT_FAIL]   = c_q.fail;
            end
            OFS_ALO: reg_rdata = c_q.alo;
            OFS_AHI: reg_rdata = c_q.ahi;
            default: reg_rdata = c_q.dat;
        endcase
    end

    assign byte_addr = {c_q.ahi, c_q.alo};
    assign byte_data = c_q.dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/nvm_shadow_ctrl.sv
module nvm_shadow_ctrl
    import nvm_shadow_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int TIMEOUT_CYC = 24,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              nvm_rd_req,
    output logic              nvm_wr_req,
    output logic [NVM_AW-1:0] nvm_addr,
    output logic [REG_W-1:0]  nvm_wdata,
    input  logic [REG_W-1:0]  nvm_rdata,
    input  logic              nvm_done,
    output logic              ram_wr,
    output logic [IDX_W-1:0]  ram_addr,
    output logic [REG_W-1:0]  ram_wdata,
    input  logic [REG_W-1:0]  ram_rdata,
    output logic              core_rst
);
    logic              start_load, start_commit, start_byte;
    logic [NVM_AW-1:0] byte_addr;
    logic [REG_W-1:0]  byte_data;
    logic              busy, load_active, commit_active;
    logic              byte_done, wr_fail;
    logic              tmo_run, tmo_expired;

    nvm_csr u_csr (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .busy          (busy),
        .load_active   (load_active),
        .commit_active (commit_active),
        .byte_done     (byte_done),
        .wr_fail       (wr_fail),
        .start_load    (start_load),
        .start_commit  (start_commit),
        .start_byte    (start_byte),
        .byte_addr     (byte_addr),
        .byte_data     (byte_data)
    );

    nvm_seq #(.DEPTH(DEPTH)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_load    (start_load),
        .start_commit  (start_commit),
        .start_byte    (start_byte),
        .byte_addr     (byte_addr),
        .byte_data     (byte_data),
        .nvm_rd_req    (nvm_rd_req),
        .nvm_wr_req    (nvm_wr_req),
        .nvm_addr      (nvm_addr),
        .nvm_wdata     (nvm_wdata),
        .nvm_rdata     (nvm_rdata),
        .nvm_done      (nvm_done),
        .ram_wr        (ram_wr),
        .ram_addr      (ram_addr),
        .ram_wdata     (ram_wdata),
        .ram_rdata     (ram_rdata),
        .tmo_expired   (tmo_expired),
        .tmo_run       (tmo_run),
        .busy          (busy),
        .load_active   (load_active),
        .commit_active (commit_active),
        .byte_done     (byte_done),
        .wr_fail       (wr_fail)
    );

    nvm_prog_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .expired (tmo_expired)
    );

    assign core_rst = load_active;
endmodule

// File: rtl/nvm_shadow_chk.sv
module nvm_shadow_chk #(
    parameter int DEPTH       = 64,
    parameter int TIMEOUT_CYC = 24,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic             nvm_rd_req,
    input logic             nvm_wr_req,
    input logic [15:0]      nvm_addr,
    input logic [7:0]       nvm_wdata,
    input logic             ram_wr,
    input logic [IDX_W-1:0] ram_addr,
    input logic             core_rst
);
    localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);
    logic [RUN_W-1:0] wr_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wr_run_q <= '0;
        else if (nvm_wr_req) wr_run_q <= wr_run_q + 1'b1;
        else                 wr_run_q <= '0;
    end

    p_wr_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_wr_req |-> (wr_run_q < RUN_W'(TIMEOUT_CYC)));

    p_shadow_only_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> core_rst);

    p_no_array_write_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> !nvm_wr_req);

    p_req_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(nvm_rd_req && nvm_wr_req));

    p_wr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_wr_req && $past(nvm_wr_req)) |-> ($stable(nvm_addr) && $stable(nvm_wdata)));

    p_shadow_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (32'(ram_addr) < DEPTH));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[3:0] == 4'd0));
endmodule

bind nvm_shadow_ctrl nvm_shadow_chk #(.DEPTH(DEPTH), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .nvm_rd_req (nvm_rd_req),
    .nvm_wr_req (nvm_wr_req),
    .nvm_addr   (nvm_addr),
    .nvm_wdata  (nvm_wdata),
    .ram_wr     (ram_wr),
    .ram_addr   (ram_addr),
    .core_rst   (core_rst)
);

// File: tb/nvm_shadow_ctrl_tb.sv
module nvm_shadow_ctrl_tb;
    localparam int DEPTH = 64;
    localparam int TMO   = 24;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LAT   = 2;
    localparam int NVEC  = 6;
    // {addr_high, addr_low, data}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h00_05_A5, 24'h00_3F_5A, 24'h01_10_C3,
        24'h00_00_FF, 24'h01_FF_00, 24'h00_20_81
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic             reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             nvm_rd_req, nvm_wr_req;
    logic [15:0]      nvm_addr;
    logic [7:0]       nvm_wdata;
    logic [7:0]       nvm_rdata = '0;
    logic             nvm_done = 1'b0;
    logic             ram_wr;
    logic [IDX_W-1:0] ram_addr;
    logic [7:0]       ram_wdata;
    logic [7:0]       ram_rdata = '0;
    logic             core_rst;

    int checks = 0, failures = 0;
    logic [7:0] nvm_mem [512];
    logic [7:0] ram_mem [DEPTH];
    logic       stall = 1'b0;
    int         nvm_cnt = 0;
    int         wr_cycles = 0;
    logic       rst_seen = 1'b0;
    int         viol = 0;
    logic [15:0] prev_addr = '0;
    logic [7:0]  prev_wdata = '0;
    logic        prev_wr = 1'b0;

    always #4 clk = ~clk;

    nvm_shadow_ctrl #(.DEPTH(DEPTH), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nvm_rd_req(nvm_rd_req), .nvm_wr_req(nvm_wr_req), .nvm_addr(nvm_addr),
        .nvm_wdata(nvm_wdata), .nvm_rdata(nvm_rdata), .nvm_done(nvm_done),
        .ram_wr(ram_wr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .core_rst(core_rst)
    );

    // array model: answers after LAT cycles unless stalled
    always @(posedge clk) begin
        nvm_done <= 1'b0;
        if ((nvm_rd_req || nvm_wr_req) && !nvm_done && !stall) begin
            if (nvm_cnt == LAT) begin
                nvm_cnt  <= 0;
                nvm_done <= 1'b1;
                if (nvm_wr_req) nvm_mem[nvm_addr[8:0]] <= nvm_wdata;
                else            nvm_rdata <= nvm_mem[nvm_addr[8:0]];
            end else begin
                nvm_cnt <= nvm_cnt + 1;
            end
        end
    end

    // shadow RAM model: synchronous read
    always @(posedge clk) begin
        if (ram_wr) ram_mem[ram_addr] <= ram_wdata;
        ram_rdata <= ram_mem[ram_addr];
    end

    // port monitors
    always @(posedge clk) begin
        if (rst_n) begin
            if (nvm_wr_req) wr_cycles <= wr_cycles + 1;
            if (core_rst) rst_seen <= 1'b1;
            if (nvm_rd_req && nvm_wr_req) viol <= viol + 1;
            if (nvm_wr_req && prev_wr && (nvm_addr != prev_addr || nvm_wdata != prev_wdata))
                viol <= viol + 1;
            prev_wr    <= nvm_wr_req;
            prev_addr  <= nvm_addr;
            prev_wdata <= nvm_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_ctrl(input int bitpos, input logic want,
                             output logic [7:0] last, output logic done_seen);
        done_seen = 1'b0;
        for (int n = 0; n < 2000; n++) begin
            reg_read(2'd0, last);
            if (last[5]) done_seen = 1'b1;
            if (last[bitpos] == want) break;
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd, last;
        logic       seen;
        logic [8:0] a9;
        int         bad;
        for (int i = 0; i < 512; i++) nvm_mem[i] = 8'((i * 37) ^ 8'h3C);
        for (int i = 0; i < DEPTH; i++) ram_mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            reg_read(2'(r), rd);
            chk("R1 register reset value", rd, 8'h00);
        end
        chk("R1 core_rst low", core_rst, 0);
        chk("R1 no requests", {nvm_rd_req, nvm_wr_req, ram_wr}, 0);

        // R2 reload with both command bits: reload wins
        reg_write(2'd0, 8'hC0);
        chk("R3 core_rst high after reload command", core_rst, 1);
        reg_read(2'd0, rd);
        chk("R4 bit7 reads 1 while reloading", rd[7], 1);
        chk("R2 commit not running with reload", rd[6], 0);
        wait_ctrl(7, 1'b0, last, seen);
        chk("R4 bit7 self-cleared", last[7], 0);
        chk("R3 core_rst released", core_rst, 0);
        chk("R7 reload sets no byte-done", seen, 0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (ram_mem[i] !== nvm_mem[i]) bad++;
        chk("R2 shadow matches array", bad, 0);

        // R6/R7 byte programs from vector table
        for (int v = 0; v < NVEC; v++) begin
            reg_write(2'd1, VEC[v][15:8]);
            reg_write(2'd2, VEC[v][23:16]);
            reg_write(2'd3, VEC[v][7:0]);
            wait_ctrl(5, 1'b1, last, seen);
            chk("R6 byte-done set", last[5], 1);
            chk("R8 no failure on good write", last[4], 0);
            a9 = {VEC[v][16], VEC[v][15:8]};
            chk("R6 array byte programmed", nvm_mem[a9], VEC[v][7:0]);
            reg_read(2'd0, rd);
            chk("R7 byte-done cleared by read", rd[5], 0);
        end

        // R5 commit with busy writes ignored (R10)
        for (int i = 0; i < DEPTH; i++) ram_mem[i] = 8'(~(i * 5));
        nvm_mem[9'h111] = 8'h6E;
        rst_seen = 1'b0;
        reg_write(2'd0, 8'h40);
        reg_read(2'd0, rd);
        chk("R5 bit6 reads 1 while committing", rd[6], 1);
        reg_write(2'd1, 8'h11);
        reg_write(2'd2, 8'h01);
        reg_write(2'd3, 8'h99);
        reg_write(2'd0, 8'h80);
        wait_ctrl(6, 1'b0, last, seen);
        chk("R5 bit6 self-cleared", last[6], 0);
        chk("R7 commit sets no byte-done", seen, 0);
        chk("R10 reload command ignored while busy", rst_seen, 0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (nvm_mem[i] !== ram_mem[i]) bad++;
        chk("R5 array matches shadow", bad, 0);
        reg_read(2'd1, rd);
        chk("R10 address-low write ignored", rd, 8'h20);
        reg_read(2'd3, rd);
        chk("R10 data write ignored", rd, 8'h81);
        chk("R10 no byte programmed while busy", nvm_mem[9'h111], 8'h6E);

        // R8 timeout on stalled array
        reg_write(2'd1, 8'h30);
        reg_write(2'd2, 8'h00);
        stall = 1'b1;
        @(negedge clk);
        wr_cycles = 0;
        reg_write(2'd3, 8'h44);
        wait_ctrl(5, 1'b1, last, seen);
        chk("R8 fail flag set", last[4], 1);
        chk("R8 timed-out byte still done", last[5], 1);
        chk("R8 request length", wr_cycles, TMO);
        chk("R8 array word unchanged", nvm_mem[9'h030], ram_mem[6'h30]);
        stall = 1'b0;

        // R9 new program clears fail at start
        reg_write(2'd3, 8'h45);
        reg_read(2'd0, rd);
        chk("R9 fail cleared at start", rd[4], 0);
        wait_ctrl(5, 1'b1, last, seen);
        chk("R9 fail stays clear", last[4], 0);
        chk("R6 retry programmed", nvm_mem[9'h030], 8'h45);
        chk("R11 reserved bits zero", last[3:0], 0);
        chk("R12 request protocol", viol, 0);

        finish_run();
    end
endmodule